// File: doc/BRIEF.md
# Multi-bank flash read-source controller

This block tracks which read mode a multi-bank NOR flash is in and, for every bus read, names the area that must supply the data. Its input is a stream of already-decoded bus write commands. Each command is a Read/Reset, an identifier-read request or a query-table request, and each carries a bank number. The block keeps the current mode, the bank each mode applies to, and the mode that was active before query mode was entered.

Query mode is limited to one bank and can be entered on top of identifier mode. It is therefore held as a two-level stack, not a flat register. One Read/Reset leaves query mode and restores the mode underneath. A second Read/Reset is needed when that mode was identifier mode. A read to the bank that owns the active mode is steered to the identifier or query area. A read to any other bank is steered to the main array. The select output is combinational, so it is valid in the same cycle as the read address.

Top module: `fmode_ctrl`

## Requirements
- R1: After a synchronous reset the block is in array mode, and a read to every bank selects the array (`rd_src_o` = 0).
- R2: In array mode, a valid identifier command (`cmd_op_i` = 1) enters identifier mode and records its bank. A read to that bank then selects the identifier area (`rd_src_o` = 1), and a read to any other bank selects the array.
- R3: In array mode, a single valid query command (`cmd_op_i` = 2) enters query mode for its bank. A read to that bank then selects the query area (`rd_src_o` = 2), and a read to any other bank selects the array.
- R4: In identifier mode, a query command whose bank equals the recorded identifier bank enters query mode. A query command with any other bank leaves identifier mode and its bank unchanged.
- R5: A Read/Reset (`cmd_op_i` = 0) in query mode restores the mode held before query entry (array, or identifier with its original bank).
- R6: When query mode was entered from identifier mode, the first Read/Reset returns to identifier mode and a second Read/Reset returns to array mode.
- R7: In query mode, identifier and query commands have no effect. In identifier mode, a further identifier command has no effect.
- R8: A Read/Reset in identifier mode returns to array mode. A Read/Reset in array mode changes nothing.
- R9: Commands with `cmd_valid_i` low, and the code `cmd_op_i` = 3, have no effect in any mode. `rd_src_o` follows `rd_bank_i` in the same cycle, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid_i | input | 1 | Decoded command strobe |
| cmd_op_i | input | 2 | Command code: 0 Read/Reset, 1 identifier, 2 query, 3 none |
| cmd_bank_i | input | BANK_W (3) | Bank field of the command |
| rd_bank_i | input | BANK_W (3) | Bank field of the current read address |
| rd_src_o | output | 2 | Read source: 0 array, 1 identifier area, 2 query area |

## Verification
The checker tests on every cycle the rules that relate one command to the next state:
- reset forces array mode;
- the identifier bank is recorded on entry;
- a query command with a mismatched bank is dropped in identifier mode;
- non-reset commands leave query mode and its bank untouched;
- a pop restores the saved mode;
- the query area is never selected outside query mode, and never for a foreign bank.

Some behaviour can only be shown by the bench's scenarios. These are the full two-step exit from nested query mode, the bank-by-bank read steering after long random command sequences, and the same-cycle response to a changing read bank. The bench drives seeded random command streams, biased towards matching banks, and checks all eight read banks after every command.

// File: rtl/fmode_pkg.sv
package fmode_pkg;

  localparam int MAX_BANK_W = 8;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_IDENT = 2'd1,
    OP_QUERY = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    MD_ARRAY = 2'd0,
    MD_IDENT = 2'd1,
    MD_QUERY = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    SRC_ARRAY = 2'd0,
    SRC_IDENT = 2'd1,
    SRC_CFI   = 2'd2
  } src_e;

  // equality of two bank fields, zero-extended to the widest bank
  function automatic logic bank_eq(logic [MAX_BANK_W-1:0] a,
                                   logic [MAX_BANK_W-1:0] b);
    return a == b;
  endfunction

  // read source from the current mode and the two bank hits
  function automatic src_e pick_src(mode_e md, logic hit_id, logic hit_q);
    src_e s;
    s = SRC_ARRAY;
    case (md)
      MD_IDENT: if (hit_id) s = SRC_IDENT;
      MD_QUERY: if (hit_q)  s = SRC_CFI;
      default:  s = SRC_ARRAY;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/fmode_dec.sv
module fmode_dec
  import fmode_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  mode_e             mode_i,
  input  logic [BANK_W-1:0] id_bank_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [BANK_W-1:0] cmd_bank_i,
  output logic              ev_ident_enter_o,
  output logic              ev_query_enter_o,
  output logic              ev_query_pop_o,
  output logic              ev_ident_exit_o,
  output logic              ev_dropped_o
);

  localparam int PADW = MAX_BANK_W - BANK_W;

  logic is_reset, is_ident, is_query, bank_match;

  assign is_reset = cmd_valid_i && (cmd_op_i == OP_RESET);
  assign is_ident = cmd_valid_i && (cmd_op_i == OP_IDENT);
  assign is_query = cmd_valid_i && (cmd_op_i == OP_QUERY);

  assign bank_match = bank_eq({{PADW{1'b0}}, cmd_bank_i},
                              {{PADW{1'b0}}, id_bank_i});

  always_comb begin
    ev_ident_enter_o = 1'b0;
    ev_query_enter_o = 1'b0;
    ev_query_pop_o   = 1'b0;
    ev_ident_exit_o  = 1'b0;
    ev_dropped_o     = 1'b0;
    case (mode_i)
      MD_ARRAY: begin
        ev_ident_enter_o = is_ident;
        ev_query_enter_o = is_query;
      end
      MD_IDENT: begin
        ev_ident_exit_o  = is_reset;
        ev_query_enter_o = is_query && bank_match;
        ev_dropped_o     = (is_query && !bank_match) || is_ident;
      end
      MD_QUERY: begin
        ev_query_pop_o = is_reset;
        ev_dropped_o   = is_ident || is_query;
      end
      default: ev_dropped_o = cmd_valid_i;
    endcase
  end

endmodule

// File: rtl/fmode_stack.sv
module fmode_stack
  import fmode_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_ident_enter_i,
  input  logic              ev_query_enter_i,
  input  logic              ev_query_pop_i,
  input  logic              ev_ident_exit_i,
  input  logic [BANK_W-1:0] cmd_bank_i,
  output mode_e             mode_o,
  output mode_e             prev_o,
  output logic [BANK_W-1:0] id_bank_o,
  output logic [BANK_W-1:0] qry_bank_o
);

  mode_e             mode_q, prev_q;
  logic [BANK_W-1:0] id_bank_q, qry_bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MD_ARRAY;
      prev_q     <= MD_ARRAY;
      id_bank_q  <= '0;
      qry_bank_q <= '0;
    end else if (ev_ident_enter_i) begin
      mode_q    <= MD_IDENT;
      id_bank_q <= cmd_bank_i;
    end else if (ev_query_enter_i) begin
      prev_q     <= mode_q;
      mode_q     <= MD_QUERY;
      qry_bank_q <= cmd_bank_i;
    end else if (ev_query_pop_i) begin
      mode_q <= prev_q;
      prev_q <= MD_ARRAY;
    end else if (ev_ident_exit_i) begin
      mode_q <= MD_ARRAY;
    end
  end

  assign mode_o     = mode_q;
  assign prev_o     = prev_q;
  assign id_bank_o  = id_bank_q;
  assign qry_bank_o = qry_bank_q;

endmodule

// File: rtl/fmode_route.sv
module fmode_route
  import fmode_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  mode_e             mode_i,
  input  logic [BANK_W-1:0] id_bank_i,
  input  logic [BANK_W-1:0] qry_bank_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  output logic [1:0]        src_o
);

  localparam int PADW = MAX_BANK_W - BANK_W;

  logic hit_id, hit_q;

  assign hit_id = bank_eq({{PADW{1'b0}}, rd_bank_i}, {{PADW{1'b0}}, id_bank_i});
  assign hit_q  = bank_eq({{PADW{1'b0}}, rd_bank_i}, {{PADW{1'b0}}, qry_bank_i});
  assign src_o  = pick_src(mode_i, hit_id, hit_q);

endmodule

// File: rtl/fmode_ctrl.sv
module fmode_ctrl
  import fmode_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [BANK_W-1:0] cmd_bank_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  output logic [1:0]        rd_src_o
);

  mode_e             mode_q, prev_q;
  logic [BANK_W-1:0] id_bank_q, qry_bank_q;
  logic              ev_ident_enter, ev_query_enter, ev_query_pop;
  logic              ev_ident_exit, ev_dropped;

  fmode_dec #(.BANK_W(BANK_W)) u_dec (
    .mode_i           (mode_q),
    .id_bank_i        (id_bank_q),
    .cmd_valid_i      (cmd_valid_i),
    .cmd_op_i         (cmd_op_i),
    .cmd_bank_i       (cmd_bank_i),
    .ev_ident_enter_o (ev_ident_enter),
    .ev_query_enter_o (ev_query_enter),
    .ev_query_pop_o   (ev_query_pop),
    .ev_ident_exit_o  (ev_ident_exit),
    .ev_dropped_o     (ev_dropped)
  );

  fmode_stack #(.BANK_W(BANK_W)) u_stack (
    .clk              (clk),
    .rst              (rst),
    .ev_ident_enter_i (ev_ident_enter),
    .ev_query_enter_i (ev_query_enter),
    .ev_query_pop_i   (ev_query_pop),
    .ev_ident_exit_i  (ev_ident_exit),
    .cmd_bank_i       (cmd_bank_i),
    .mode_o           (mode_q),
    .prev_o           (prev_q),
    .id_bank_o        (id_bank_q),
    .qry_bank_o       (qry_bank_q)
  );

  fmode_route #(.BANK_W(BANK_W)) u_route (
    .mode_i     (mode_q),
    .id_bank_i  (id_bank_q),
    .qry_bank_i (qry_bank_q),
    .rd_bank_i  (rd_bank_i),
    .src_o      (rd_src_o)
  );

endmodule

// File: rtl/fmode_chk.sv
module fmode_chk
  import fmode_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid_i,
  input logic [1:0]        cmd_op_i,
  input logic [BANK_W-1:0] cmd_bank_i,
  input logic [BANK_W-1:0] rd_bank_i,
  input logic [1:0]        rd_src_o,
  input mode_e             mode_q,
  input mode_e             prev_q,
  input logic [BANK_W-1:0] id_bank_q,
  input logic [BANK_W-1:0] qry_bank_q,
  input logic              ev_dropped
);

  AST_RESET_TO_ARRAY: assert property (@(posedge clk)
    rst |=> (mode_q == MD_ARRAY)); // R1

  AST_IDENT_RECORDS_BANK: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && cmd_op_i == OP_IDENT && mode_q == MD_ARRAY)
    |=> (mode_q == MD_IDENT && id_bank_q == $past(cmd_bank_i))); // R2

  AST_QUERY_MISMATCH_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && cmd_op_i == OP_QUERY && mode_q == MD_IDENT && cmd_bank_i != id_bank_q)
    |=> (mode_q == MD_IDENT && $stable(id_bank_q))); // R4

  AST_POP_RESTORES: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && cmd_op_i == OP_RESET && mode_q == MD_QUERY)
    |=> (mode_q == $past(prev_q))); // R5

  AST_QUERY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && cmd_op_i != OP_RESET && mode_q == MD_QUERY)
    |=> (mode_q == MD_QUERY && $stable(qry_bank_q))); // R7

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid_i || cmd_op_i == OP_NONE) |=> $stable(mode_q)); // R9

  AST_CFI_ONLY_OWN_BANK: assert property (@(posedge clk) disable iff (rst)
    (rd_src_o == SRC_CFI) |-> (mode_q == MD_QUERY && rd_bank_i == qry_bank_q)); // R3

  AST_DROP_IS_VALID: assert property (@(posedge clk) disable iff (rst)
    ev_dropped |-> (cmd_valid_i && cmd_op_i != OP_RESET && mode_q != MD_ARRAY)); // R7

endmodule

bind fmode_ctrl fmode_chk #(.BANK_W(BANK_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .cmd_bank_i  (cmd_bank_i),
  .rd_bank_i   (rd_bank_i),
  .rd_src_o    (rd_src_o),
  .mode_q      (mode_q),
  .prev_q      (prev_q),
  .id_bank_q   (id_bank_q),
  .qry_bank_q  (qry_bank_q),
  .ev_dropped  (ev_dropped)
);

// File: tb/fmode_ctrl_tb.sv
`timescale 1ns/1ps
module fmode_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid_i = 1'b0;
  logic [1:0] cmd_op_i = 2'd3;
  logic [2:0] cmd_bank_i = '0;
  logic [2:0] rd_bank_i = '0;
  logic [1:0] rd_src_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state: 0 array, 1 identifier, 2 query
  int m_mode = 0, m_prev = 0, m_ib = 0, m_qb = 0;

  always #2 clk = ~clk;

  fmode_ctrl #(.BANK_W(3)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_bank_i(cmd_bank_i), .rd_bank_i(rd_bank_i), .rd_src_o(rd_src_o)
  );

  function automatic int exp_src(int rb);
    if (m_mode == 1 && rb == m_ib) return 1;
    if (m_mode == 2 && rb == m_qb) return 2;
    return 0;
  endfunction

  // reference transition; returns the requirement the step exercises
  function automatic string model_step(bit v, int op, int bk);
    if (!v || op == 3) return "R9";
    case (m_mode)
      0: begin
        if (op == 1) begin m_mode = 1; m_ib = bk; return "R2"; end
        if (op == 2) begin m_prev = 0; m_mode = 2; m_qb = bk; return "R3"; end
        return "R8";
      end
      1: begin
        if (op == 0) begin m_mode = 0; return "R8"; end
        if (op == 2 && bk == m_ib) begin m_prev = 1; m_mode = 2; m_qb = bk; return "R4"; end
        if (op == 2) return "R4";
        return "R7";
      end
      default: begin
        if (op == 0) begin
          string t;
          t = (m_prev == 1) ? "R6" : "R5";
          m_mode = m_prev; m_prev = 0;
          return t;
        end
        return "R7";
      end
    endcase
  endfunction

  task automatic check_all(string tag);
    for (int b = 0; b < 8; b++) begin
      rd_bank_i = 3'(b);
      #0.1;
      checks++;
      if (int'(rd_src_o) != exp_src(b)) begin
        errors++;
        $display("FAIL %s bank=%0d actual=%0d expected=%0d", tag, b, rd_src_o, exp_src(b));
      end
    end
  endtask

  task automatic issue(bit v, int op, int bk);
    string tag;
    @(negedge clk);
    cmd_valid_i = v; cmd_op_i = 2'(op); cmd_bank_i = 3'(bk);
    @(posedge clk);
    tag = model_step(v, op, bk);
    @(negedge clk);
    cmd_valid_i = 1'b0; cmd_op_i = 2'd3;
    check_all(tag);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check_all("R1");
    // directed corners
    issue(1, 1, 5);      // R2 enter identifier on bank 5
    issue(1, 1, 3);      // R7 second identifier ignored
    issue(1, 2, 2);      // R4 mismatched query dropped
    issue(1, 2, 5);      // R4 matching query nests
    issue(1, 1, 0);      // R7 ignored in query
    issue(1, 2, 6);      // R7 query bank kept
    issue(0, 0, 0);      // R9 strobe low
    issue(1, 3, 1);      // R9 code 3
    issue(1, 0, 0);      // R6 first pop -> identifier bank 5
    issue(1, 0, 0);      // R6 second -> array
    issue(1, 0, 0);      // R8 reset in array
    issue(1, 2, 7);      // R3 query from array
    issue(1, 0, 0);      // R5 pop -> array
    // R9 same-cycle response: change read bank with no clock edge
    issue(1, 1, 4);
    check_all("R9");
    // random phase
    for (int i = 0; i < 600; i++) begin
      int op, bk;
      op = int'($urandom % 4);
      bk = ((m_mode == 1) && ($urandom % 2 == 0)) ? m_ib : int'($urandom % 8);
      issue(($urandom % 8) != 0, op, bk);
    end
    // reset mid-query
    issue(1, 2, 3);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_mode = 0; m_prev = 0; m_ib = 0; m_qb = 0;
    check_all("R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule